// File: doc/BRIEF.md
# Packed Byte Widening Add/Subtract Unit

This block is a small SIMD execution unit attached to a sixteen-entry, 32-bit extension register file. Entry 0 of that file is hard-wired to zero. On each issue pulse the unit decodes a 32-bit instruction word and reads two source registers, B and C. It combines their four byte pairs into four 16-bit lanes. The upper two lanes are written to destination A and the lower two lanes to destination D. Each byte is zero-extended before use. A 2-bit pattern field chooses, for each destination, whether its byte pairs are added or subtracted.

An accumulating form of the instruction also reads the current contents of both destinations. It adds their existing 16-bit lanes into the new results before truncation. The surrounding pipeline loads and inspects the register file through one plain write port and one plain read port. Both destination writes of an instruction land on the same clock edge.

Top module: `pbw_unit`

## Requirements
- R1: An issue pulse executes only when insn[5:0] is 0x1C with insn[23:22] equal to 0 (plain form), or when insn[5:0] is 0x1D (accumulating form, insn[23:22] ignored). Any other encoding writes no register.
- R2: Destination A (index insn[9:6]) receives the byte-2 result of B (insn[13:10]) and C (insn[17:14]) in bits [15:0], and the byte-3 result in bits [31:16].
- R3: Destination D (index insn[21:18]) receives the byte-0 result in bits [15:0] and the byte-1 result in bits [31:16].
- R4: Pattern bit insn[25] set makes both A lanes compute B byte minus C byte, and clear makes them add. Pattern bit insn[24] controls both D lanes in the same way.
- R5: Bytes are zero-extended to 16 bits before the operation, and every lane result is truncated to 16 bits (for example 0x02 - 0x04 gives 0xFFFE).
- R6: In the accumulating form, each lane's old 16-bit value, read from its destination before the write, is added to the new lane result modulo 2^16.
- R7: When both source indices are 0, both destinations are written with zero, in both forms.
- R8: Index 0 always reads as zero. Any write aimed at index 0, from an instruction or from the external write port, is discarded.
- R9: When A and D name the same register, that register ends up holding the D result.
- R10: Both destination writes become visible on the read port right after the clock edge that samples issue_valid high. Without an issue pulse or an external write, no register changes.
- R11: Synchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | One-cycle pulse that executes insn |
| insn | input | 32 | Instruction word |
| ext_we | input | 1 | External register write enable (instruction writes take precedence) |
| ext_widx | input | 4 | External write index |
| ext_wdata | input | 32 | External write data |
| ext_ridx | input | 4 | External read index |
| ext_rdata | output | 32 | Combinational read data for ext_ridx |

## Verification
A wrong lane routing, pattern-bit mapping or carry width shows up on the read port one cycle after the issue pulse. It appears as a misplaced or mis-signed 16-bit half of a destination. A fault in the accumulate path, or a stale register, stays hidden until that register is read back. For that reason the bench reads every entry after every instruction, so a corrupted register is caught before the next instruction issues. Faults in decoding, index 0 handling or A/D collisions show as a register that changes when it must not, or that holds the wrong one of two results.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 16;
    localparam int IDXW    = $clog2(NREG);
    localparam int BYTEW   = 8;
    localparam int LANEW   = 2 * BYTEW;
    localparam int NPAIR   = 2;                 // pair 0 -> D, pair 1 -> A
    localparam int LPP     = XLEN / LANEW;      // lanes per destination
    localparam logic [5:0] MAJ_PLAIN = 6'h1C;
    localparam logic [5:0] MAJ_ACC   = 6'h1D;

    typedef logic [IDXW-1:0] ridx_t;
    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic        go;
        logic        acc;
        logic [1:0]  ptn;
        ridx_t       xd;
        ridx_t       xc;
        ridx_t       xb;
        ridx_t       xa;
    } op_t;

    // one widened lane: zero-extend, add or subtract, optional accumulate
    function automatic logic [LANEW-1:0] lane_op(
        input logic [BYTEW-1:0] b, input logic [BYTEW-1:0] c,
        input logic sub, input logic [LANEW-1:0] old);
        logic [LANEW-1:0] bz, cz;
        bz = {{(LANEW-BYTEW){1'b0}}, b};
        cz = {{(LANEW-BYTEW){1'b0}}, c};
        return (sub ? (bz - cz) : (bz + cz)) + old;
    endfunction
endpackage

// File: rtl/pbw_decode.sv
module pbw_decode
    import pbw_pkg::*;
(
    input  logic        issue_valid,
    input  logic [31:0] insn,
    output op_t         op
);
    logic [5:0] major;
    logic [1:0] minor;
    logic       is_plain, is_acc;

    assign major    = insn[5:0];
    assign minor    = insn[23:22];
    assign is_plain = (major == MAJ_PLAIN) && (minor == 2'b00);
    assign is_acc   = (major == MAJ_ACC);

    always_comb begin
        op.go  = issue_valid && (is_plain || is_acc);
        op.acc = is_acc;
        op.ptn = insn[25:24];
        op.xd  = insn[21:18];
        op.xc  = insn[17:14];
        op.xb  = insn[13:10];
        op.xa  = insn[9:6];
    end

    // R1: a word outside the two legal encodings never starts an operation
    always_comb begin
        a_r1_no_stray_go: assert (!op.go || is_plain || is_acc);
    end
endmodule

// File: rtl/pbw_regfile.sv
module pbw_regfile
    import pbw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ridx_t  rb_idx,
    input  ridx_t  rc_idx,
    input  ridx_t  oa_idx,
    input  ridx_t  od_idx,
    input  ridx_t  x_ridx,
    output word_t  rb_data,
    output word_t  rc_data,
    output word_t  oa_data,
    output word_t  od_data,
    output word_t  x_rdata,
    input  logic   wa_en,
    input  ridx_t  wa_idx,
    input  word_t  wa_data,
    input  logic   wd_en,
    input  ridx_t  wd_idx,
    input  word_t  wd_data,
    input  logic   x_we,
    input  ridx_t  x_widx,
    input  word_t  x_wdata
);
    word_t mem [1:NREG-1];

    function automatic word_t rd(input ridx_t i);
        return (i == '0) ? '0 : mem[i];
    endfunction

    assign rb_data = rd(rb_idx);
    assign rc_data = rd(rc_idx);
    assign oa_data = rd(oa_idx);
    assign od_data = rd(od_idx);
    assign x_rdata = rd(x_ridx);

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)                                 mem[g] <= '0;
                else if (wd_en && wd_idx == ridx_t'(g))  mem[g] <= wd_data;
                else if (wa_en && wa_idx == ridx_t'(g))  mem[g] <= wa_data;
                else if (x_we  && x_widx == ridx_t'(g))  mem[g] <= x_wdata;
            end

            // R10: an entry with no write pending keeps its value
            a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
                !((wd_en && wd_idx == ridx_t'(g)) || (wa_en && wa_idx == ridx_t'(g)) ||
                  (x_we && x_widx == ridx_t'(g))) |=> $stable(mem[g]));
        end
    endgenerate

    // R9: the D write always lands, even on top of an A write to the same entry
    a_r9_d_wins: assert property (@(posedge clk) disable iff (rst)
        (wd_en && wd_idx != '0) |=> rd($past(wd_idx)) == $past(wd_data));

    // R8: entry 0 reads as zero
    always_comb begin
        a_r8_zero_entry: assert (x_ridx != '0 || x_rdata == '0);
    end
endmodule

// File: rtl/pbw_lanes.sv
module pbw_lanes
    import pbw_pkg::*;
(
    input  op_t    op,
    input  word_t  b_data,
    input  word_t  c_data,
    input  word_t  olda,
    input  word_t  oldd,
    output word_t  res_a,
    output word_t  res_d
);
    logic  both_zero;
    word_t old_w [NPAIR];
    word_t res_w [NPAIR];

    assign both_zero = (op.xb == '0) && (op.xc == '0);
    assign old_w[0]  = op.acc ? oldd : '0;
    assign old_w[1]  = op.acc ? olda : '0;

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            for (genvar l = 0; l < LPP; l++) begin : g_lane
                localparam int BI = p * LPP + l;
                assign res_w[p][l*LANEW +: LANEW] = both_zero ? '0 :
                    lane_op(b_data[BI*BYTEW +: BYTEW], c_data[BI*BYTEW +: BYTEW],
                            op.ptn[p], old_w[p][l*LANEW +: LANEW]);
            end
        end
    endgenerate

    assign res_d = res_w[0];
    assign res_a = res_w[1];

    // R7: zero sources without accumulation give zero lanes from the arithmetic itself
    always_comb begin
        a_r7_zero_math: assert (!(b_data == '0 && c_data == '0 && !op.acc && op.ptn == 2'b00)
                                || (res_a == '0 && res_d == '0));
    end
endmodule

// File: rtl/pbw_unit.sv
module pbw_unit
    import pbw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_valid,
    input  logic [31:0] insn,
    input  logic        ext_we,
    input  logic [3:0]  ext_widx,
    input  logic [31:0] ext_wdata,
    input  logic [3:0]  ext_ridx,
    output logic [31:0] ext_rdata
);
    op_t   op;
    word_t b_data, c_data, olda, oldd, res_a, res_d;
    logic  wa_en, wd_en;

    pbw_decode u_dec (
        .issue_valid (issue_valid),
        .insn        (insn),
        .op          (op)
    );

    assign wa_en = op.go && (op.xa != '0);
    assign wd_en = op.go && (op.xd != '0);

    pbw_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .rb_idx  (op.xb),
        .rc_idx  (op.xc),
        .oa_idx  (op.xa),
        .od_idx  (op.xd),
        .x_ridx  (ext_ridx),
        .rb_data (b_data),
        .rc_data (c_data),
        .oa_data (olda),
        .od_data (oldd),
        .x_rdata (ext_rdata),
        .wa_en   (wa_en),
        .wa_idx  (op.xa),
        .wa_data (res_a),
        .wd_en   (wd_en),
        .wd_idx  (op.xd),
        .wd_data (res_d),
        .x_we    (ext_we),
        .x_widx  (ext_widx),
        .x_wdata (ext_wdata)
    );

    pbw_lanes u_lanes (
        .op     (op),
        .b_data (b_data),
        .c_data (c_data),
        .olda   (olda),
        .oldd   (oldd),
        .res_a  (res_a),
        .res_d  (res_d)
    );

    // R7: both sources at index 0 clear both written destinations
    a_r7_zero_sources: assert property (@(posedge clk) disable iff (rst)
        (op.go && op.xb == '0 && op.xc == '0) |-> (res_a == '0 && res_d == '0));
endmodule

// File: tb/tb_pbw_unit.sv
module tb_pbw_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [31:0] insn;
    logic        ext_we;
    logic [3:0]  ext_widx;
    logic [31:0] ext_wdata;
    logic [3:0]  ext_ridx;
    logic [31:0] ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pbw_unit dut (.*);

    function automatic logic [31:0] enc(input logic [5:0] maj, input logic [1:0] mnr,
        input logic [1:0] ptn, input logic [3:0] xd, input logic [3:0] xc,
        input logic [3:0] xb, input logic [3:0] xa);
        return {6'b011100, ptn, mnr, xd, xc, xb, xa, maj};
    endfunction

    function automatic logic [15:0] lane(input logic [7:0] b, input logic [7:0] c,
                                         input logic sub, input logic [15:0] old);
        int v;
        v = sub ? (int'(b) - int'(c)) : (int'(b) + int'(c));
        v = v + int'(old);
        return v[15:0];
    endfunction

    task automatic model_exec(input logic [31:0] w);
        logic [31:0] b, c, oa, od, ra, rd;
        logic acc, go;
        go  = (w[5:0] == 6'h1C && w[23:22] == 2'b00) || (w[5:0] == 6'h1D);
        acc = (w[5:0] == 6'h1D);
        if (!go) return;
        b  = m[w[13:10]]; c = m[w[17:14]];
        oa = acc ? m[w[9:6]] : 32'h0;
        od = acc ? m[w[21:18]] : 32'h0;
        if (w[13:10] == 4'd0 && w[17:14] == 4'd0) begin
            ra = 32'h0; rd = 32'h0;
        end else begin
            ra = {lane(b[31:24], c[31:24], w[25], oa[31:16]),
                  lane(b[23:16], c[23:16], w[25], oa[15:0])};
            rd = {lane(b[15:8],  c[15:8],  w[24], od[31:16]),
                  lane(b[7:0],   c[7:0],   w[24], od[15:0])};
        end
        if (w[9:6]   != 4'd0) m[w[9:6]]   = ra;
        if (w[21:18] != 4'd0) m[w[21:18]] = rd;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] i, output logic [31:0] v);
        ext_ridx = i;
        #1;
        v = ext_rdata;
    endtask

    task automatic check_reg(input string tag, input logic [3:0] i, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(i, v);
        check($sformatf("%s reg%0d", tag, i), v, exp);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) check_reg(tag, 4'(i), m[i]);
    endtask

    task automatic ext_write(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_widx = i; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
        if (i != 4'd0) m[i] = d;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        issue_valid = 1'b1; insn = w;
        @(negedge clk);
        issue_valid = 1'b0;
        model_exec(w);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        rst = 1'b1; issue_valid = 1'b0; insn = '0;
        ext_we = 1'b0; ext_widx = '0; ext_wdata = '0; ext_ridx = '0;
        for (int i = 0; i < 16; i++) m[i] = 32'h0;
        void'($urandom(32'd12345));
        ext_write(4'd5, 32'hDEADBEEF);   // loaded under reset, then cleared
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m[5] = 32'h0;
        check_all("R11 reset");

        ext_write(4'd1, 32'h80FF0102);
        ext_write(4'd2, 32'h01FF0304);
        ext_write(4'd7, 32'h12345678);

        // R2, R3: plain add
        issue(enc(6'h1C, 2'b00, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3));
        check_reg("R2 add A lanes", 4'd3, 32'h008101FE);
        check_reg("R3 add D lanes", 4'd4, 32'h00040006);
        // R4: subtract on A only
        issue(enc(6'h1C, 2'b00, 2'b10, 4'd4, 4'd2, 4'd1, 4'd3));
        check_reg("R4 sub A", 4'd3, 32'h007F0000);
        check_reg("R4 add D", 4'd4, 32'h00040006);
        // R4, R5: subtract on D only, wraps to 16 bits
        issue(enc(6'h1C, 2'b00, 2'b01, 4'd4, 4'd2, 4'd1, 4'd3));
        check_reg("R4 add A", 4'd3, 32'h008101FE);
        check_reg("R5 sub D wrap", 4'd4, 32'hFFFEFFFE);
        // R6: accumulate into existing lanes, minor field ignored
        issue(enc(6'h1D, 2'b11, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3));
        check_reg("R6 acc A", 4'd3, 32'h010203FC);
        check_reg("R6 acc D wrap", 4'd4, 32'h00020004);
        // R7: both sources zero, accumulating form
        issue(enc(6'h1D, 2'b00, 2'b11, 4'd4, 4'd0, 4'd0, 4'd3));
        check_reg("R7 zero A", 4'd3, 32'h0);
        check_reg("R7 zero D", 4'd4, 32'h0);
        // R8: destination A at index 0, external write to index 0
        issue(enc(6'h1C, 2'b00, 2'b00, 4'd5, 4'd2, 4'd1, 4'd0));
        check_reg("R8 dest0 D still written", 4'd5, 32'h00040006);
        check_reg("R8 index0 after insn", 4'd0, 32'h0);
        ext_write(4'd0, 32'hFFFFFFFF);
        check_reg("R8 index0 after ext write", 4'd0, 32'h0);
        // R9: same destination, D result wins
        issue(enc(6'h1C, 2'b00, 2'b00, 4'd6, 4'd2, 4'd1, 4'd6));
        check_reg("R9 D wins", 4'd6, 32'h00040006);
        // R1: illegal encodings do nothing
        issue(enc(6'h1C, 2'b01, 2'b00, 4'd7, 4'd2, 4'd1, 4'd7));
        check_reg("R1 minor nonzero", 4'd7, 32'h12345678);
        issue(enc(6'h1B, 2'b00, 2'b00, 4'd7, 4'd2, 4'd1, 4'd7));
        check_reg("R1 other major", 4'd7, 32'h12345678);
        // R10: legal word without an issue pulse
        @(negedge clk);
        insn = enc(6'h1C, 2'b00, 2'b00, 4'd7, 4'd2, 4'd1, 4'd7);
        @(negedge clk);
        check_reg("R10 no pulse", 4'd7, 32'h12345678);
        check_all("R10 directed state");

        // random mix, all registers compared against the model (R1 R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 300; n++) begin
            logic [5:0] maj;
            logic [1:0] mnr;
            int sel;
            if (($urandom % 3) == 0) ext_write(4'($urandom % 16), $urandom);
            sel = $urandom % 8;
            maj = (sel < 3) ? 6'h1C : (sel < 6) ? 6'h1D : 6'($urandom);
            mnr = (sel < 2) ? 2'b00 : 2'($urandom);
            w = enc(maj, mnr, 2'($urandom), 4'($urandom % 16), 4'($urandom % 16),
                    4'($urandom % 16), 4'($urandom % 16));
            if (($urandom % 8) == 0) w[17:10] = 8'h00;
            if (($urandom % 8) == 0) w[21:18] = w[9:6];
            issue(w);
            check_all("RAND R2,R3,R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule